// File: doc/BRIEF.md
# Dual-Location Atomic Compare-and-Swap Unit

This unit performs one indivisible compare-and-swap across two independent memory locations. A command names four registers through a packed select field: two compare operands and two update operands. It also carries two addresses and an operand width of 16 or 32 bits. The unit fetches the four register operands through a single register-file read port. It then locks the memory bus and reads both locations. Both locations are written with the update operands only if each fetched value equals its compare operand at the selected width.

Whatever the outcome, each compare register receives the value fetched from its own location. In 16-bit mode only the low half of that register is replaced. The unit then presents the flags of a subtraction (memory value minus compare operand). The flags come from the first pair when that pair differed, and from the second pair otherwise. A one-cycle completion pulse closes the command. A new command is taken only while the unit is idle.

Top module: `dcas_unit`

## Requirements
- R1: The select field is decoded as first compare register in bits 11:9, second compare register in bits 8:6, first update register in bits 5:3 and second update register in bits 2:0. Only the two compare registers are written back, and no other register changes.
- R2: Every command reads the first address and then the second address, as the first two bus accesses.
- R3: When both comparisons hold, the update operands are written as two further accesses: the first update value to the first address, then the second update value to the second address. Otherwise no write is issued and memory is unchanged.
- R4: The flags come from the first pair (first memory value, first compare operand) when those differ at the selected width, and from the second pair otherwise.
- R5: With D = memory value minus compare operand at the selected width: N is the top bit of D, Z is set when D is zero, V is the signed overflow of the subtraction, and C is set when the memory value is unsigned-below the compare operand. The flag outputs are held until the next command ends.
- R6: Each compare register is written with the value read from its own address, first the first register and then the second, so the second pair wins when both name the same register. In 16-bit mode (`op_wide`=0) bits 31:16 keep the register's prior contents.
- R7: With `op_wide`=0, comparisons, flags and memory writes use only bits 15:0, and differences in bits 31:16 have no effect. With `op_wide`=1 all 32 bits are used.
- R8: `mem_lock` is high on every cycle from the first read through the last bus access of the command (the second write, or the second read when no write occurs), and low otherwise.
- R9: `done` is a single-cycle pulse that ends each command. A `start` seen while `busy` is high is ignored.
- R10: After reset the unit is idle: `busy`, `done`, `mem_req`, `mem_lock` and `rf_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, taken only when idle |
| reg_sel | input | 12 | Packed register indices (see R1) |
| addr_a | input | ADDR_W | First memory address |
| addr_b | input | ADDR_W | Second memory address |
| op_wide | input | 1 | 1 = 32-bit operands, 0 = 16-bit operands |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_raddr | output | 3 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data (same cycle) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 3 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_wide | output | 1 | Access width, 1 = 32 bits, 0 = low 16 bits |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data |
| mem_ack | input | 1 | Access completes in this cycle |
| mem_lock | output | 1 | Bus held exclusively |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Borrow flag |

## Verification
The bench builds the unit with a 4-bit address and the default 3-bit register index. Every register and every memory word therefore lives in a small model that can be compared in full after each command. At both widths it crosses five edge operands (zero, one, largest positive, most negative, all ones) for the first pair while the second matches, and then for the second pair while the first matches. This covers every borrow and overflow corner and both flag sources. In 16-bit mode the upper halves differ on purpose, and a case with both compare indices the same shows the write-back order.

// File: rtl/dcas_pkg.sv
package dcas_pkg;

    localparam int DATA_W = 32;
    localparam int HALF_W = 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RC1,
        ST_RC2,
        ST_RU1,
        ST_RU2,
        ST_MR1,
        ST_MR2,
        ST_MW1,
        ST_MW2,
        ST_WB1,
        ST_WB2,
        ST_FIN
    } dcas_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;

    // equality at the operand width
    function automatic logic same_at(input logic [DATA_W-1:0] a,
                                     input logic [DATA_W-1:0] b,
                                     input logic wide);
        if (wide)
            return a == b;
        return a[HALF_W-1:0] == b[HALF_W-1:0];
    endfunction

    // replace low half only in narrow mode
    function automatic logic [DATA_W-1:0] merge_low(input logic [DATA_W-1:0] old_v,
                                                     input logic [DATA_W-1:0] new_v,
                                                     input logic wide);
        if (wide)
            return new_v;
        return {old_v[DATA_W-1:HALF_W], new_v[HALF_W-1:0]};
    endfunction

    // flags of m - c at the operand width
    function automatic cc_t sub_flags(input logic [DATA_W-1:0] m,
                                      input logic [DATA_W-1:0] c,
                                      input logic wide);
        cc_t r;
        logic [DATA_W:0] dw;
        logic [HALF_W:0] dh;
        dw = {1'b0, m} - {1'b0, c};
        dh = {1'b0, m[HALF_W-1:0]} - {1'b0, c[HALF_W-1:0]};
        if (wide) begin
            r.n = dw[DATA_W-1];
            r.z = (dw[DATA_W-1:0] == '0);
            r.c = dw[DATA_W];
            r.v = (m[DATA_W-1] ^ c[DATA_W-1]) & (dw[DATA_W-1] ^ m[DATA_W-1]);
        end else begin
            r.n = dh[HALF_W-1];
            r.z = (dh[HALF_W-1:0] == '0);
            r.c = dh[HALF_W];
            r.v = (m[HALF_W-1] ^ c[HALF_W-1]) & (dh[HALF_W-1] ^ m[HALF_W-1]);
        end
        return r;
    endfunction

endpackage

// File: rtl/dcas_seq.sv
module dcas_seq
    import dcas_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        mem_ack,
    input  logic        both_eq,
    output dcas_state_e state
);

    dcas_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start) nxt = ST_RC1;
            ST_RC1:  nxt = ST_RC2;
            ST_RC2:  nxt = ST_RU1;
            ST_RU1:  nxt = ST_RU2;
            ST_RU2:  nxt = ST_MR1;
            ST_MR1:  if (mem_ack) nxt = ST_MR2;
            ST_MR2:  if (mem_ack) nxt = both_eq ? ST_MW1 : ST_WB1;
            ST_MW1:  if (mem_ack) nxt = ST_MW2;
            ST_MW2:  if (mem_ack) nxt = ST_WB1;
            ST_WB1:  nxt = ST_WB2;
            ST_WB2:  nxt = ST_FIN;
            ST_FIN:  nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

endmodule

// File: rtl/dcas_cc_pick.sv
module dcas_cc_pick
    import dcas_pkg::*;
(
    input  logic [DATA_W-1:0] mem_v1,
    input  logic [DATA_W-1:0] mem_v2,
    input  logic [DATA_W-1:0] cmp_v1,
    input  logic [DATA_W-1:0] cmp_v2,
    input  logic              wide,
    output cc_t               cc
);

    cc_t cc_first;
    cc_t cc_second;

    always_comb begin
        cc_first  = sub_flags(mem_v1, cmp_v1, wide);
        cc_second = sub_flags(mem_v2, cmp_v2, wide);
        // first pair decides when it mismatched
        cc = same_at(mem_v1, cmp_v1, wide) ? cc_second : cc_first;
    end

endmodule

// File: rtl/dcas_unit.sv
module dcas_unit
    import dcas_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int REG_IDX_W = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [4*REG_IDX_W-1:0] reg_sel,
    input  logic [ADDR_W-1:0]    addr_a,
    input  logic [ADDR_W-1:0]    addr_b,
    input  logic                 op_wide,
    output logic                 busy,
    output logic                 done,
    output logic [REG_IDX_W-1:0] rf_raddr,
    input  logic [DATA_W-1:0]    rf_rdata,
    output logic                 rf_we,
    output logic [REG_IDX_W-1:0] rf_waddr,
    output logic [DATA_W-1:0]    rf_wdata,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic                 mem_wide,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata,
    input  logic                 mem_ack,
    output logic                 mem_lock,
    output logic                 flag_n,
    output logic                 flag_z,
    output logic                 flag_v,
    output logic                 flag_c
);

    localparam int N_FIELDS = 4;
    localparam int SEL_W    = N_FIELDS * REG_IDX_W;
    // field order: cmp1, cmp2, upd1, upd2 (most significant first)
    localparam int F_C1 = 0;
    localparam int F_C2 = 1;
    localparam int F_U1 = 2;
    localparam int F_U2 = 3;

    dcas_state_e          state;
    logic [SEL_W-1:0]     sel_q;
    logic [ADDR_W-1:0]    a1_q, a2_q;
    logic                 wide_q;
    logic [REG_IDX_W-1:0] fld [N_FIELDS];
    logic [DATA_W-1:0]    opnd [N_FIELDS];
    logic [DATA_W-1:0]    got1_q, got2_q;
    logic                 eq1_q;
    logic                 both_eq;
    logic                 rd_phase;
    logic [1:0]           rd_idx;
    cc_t                  cc_now, cc_q;

    generate
        for (genvar k = 0; k < N_FIELDS; k++) begin : g_fld
            assign fld[k] = sel_q[SEL_W-1-k*REG_IDX_W -: REG_IDX_W];
        end
    endgenerate

    dcas_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .mem_ack (mem_ack),
        .both_eq (both_eq),
        .state   (state)
    );

    dcas_cc_pick u_cc (
        .mem_v1 (got1_q),
        .mem_v2 (got2_q),
        .cmp_v1 (opnd[F_C1]),
        .cmp_v2 (opnd[F_C2]),
        .wide   (wide_q),
        .cc     (cc_now)
    );

    assign both_eq = eq1_q && same_at(mem_rdata, opnd[F_C2], wide_q);

    always_comb begin
        rd_phase = 1'b1;
        unique case (state)
            ST_RC1:  rd_idx = 2'(F_C1);
            ST_RC2:  rd_idx = 2'(F_C2);
            ST_RU1:  rd_idx = 2'(F_U1);
            ST_RU2:  rd_idx = 2'(F_U2);
            default: begin
                rd_idx   = 2'(F_C1);
                rd_phase = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            a1_q   <= '0;
            a2_q   <= '0;
            wide_q <= 1'b0;
            got1_q <= '0;
            got2_q <= '0;
            eq1_q  <= 1'b0;
            cc_q   <= '0;
            for (int k = 0; k < N_FIELDS; k++)
                opnd[k] <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                sel_q  <= reg_sel;
                a1_q   <= addr_a;
                a2_q   <= addr_b;
                wide_q <= op_wide;
            end
            if (rd_phase)
                opnd[rd_idx] <= rf_rdata;
            if (state == ST_MR1 && mem_ack) begin
                got1_q <= mem_rdata;
                eq1_q  <= same_at(mem_rdata, opnd[F_C1], wide_q);
            end
            if (state == ST_MR2 && mem_ack)
                got2_q <= mem_rdata;
            if (state == ST_WB1)
                cc_q <= cc_now;
        end
    end

    always_comb begin
        mem_req   = (state == ST_MR1) || (state == ST_MR2) ||
                    (state == ST_MW1) || (state == ST_MW2);
        mem_we    = (state == ST_MW1) || (state == ST_MW2);
        mem_addr  = ((state == ST_MR1) || (state == ST_MW1)) ? a1_q : a2_q;
        mem_wdata = (state == ST_MW1) ? opnd[F_U1] : opnd[F_U2];
        mem_wide  = wide_q;
        mem_lock  = mem_req;
        rf_raddr  = fld[rd_idx];
        rf_we     = (state == ST_WB1) || (state == ST_WB2);
        rf_waddr  = (state == ST_WB1) ? fld[F_C1] : fld[F_C2];
        rf_wdata  = (state == ST_WB1) ? merge_low(opnd[F_C1], got1_q, wide_q)
                                      : merge_low(opnd[F_C2], got2_q, wide_q);
        busy      = (state != ST_IDLE);
        done      = (state == ST_FIN);
    end

    assign flag_n = cc_q.n;
    assign flag_z = cc_q.z;
    assign flag_v = cc_q.v;
    assign flag_c = cc_q.c;

endmodule

// File: rtl/dcas_unit_chk.sv
module dcas_unit_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic rf_we,
    input logic mem_req,
    input logic mem_we,
    input logic mem_lock
);

    // R8
    lock_into_write_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> $past(mem_lock));

    // R8
    lock_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_lock |-> busy);

    // R6
    wb_after_release_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> !mem_lock);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_in_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R9
    idle_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> busy);

endmodule

bind dcas_unit dcas_unit_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .rf_we    (rf_we),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_lock (mem_lock)
);

// File: tb/dcas_unit_tb_top.sv
module dcas_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 4;
    localparam int RW         = 3;
    localparam int WATCHDOG   = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [4*RW-1:0] reg_sel = '0;
    logic [AW-1:0] addr_a = '0, addr_b = '0;
    logic          op_wide = 1'b0;
    logic          busy, done, rf_we, mem_req, mem_we, mem_wide, mem_ack, mem_lock;
    logic [RW-1:0] rf_raddr, rf_waddr;
    logic [31:0]   rf_rdata, rf_wdata, mem_wdata, mem_rdata;
    logic [AW-1:0] mem_addr;
    logic          flag_n, flag_z, flag_v, flag_c;

    logic [31:0]   mem_arr [16];
    logic [31:0]   rf_arr  [8];
    logic          pl_en = 1'b0, pl_mem = 1'b0;
    int            pl_idx = 0;
    logic [31:0]   pl_val = '0;
    logic          tr_clr = 1'b0;
    int            tr_n = 0, lock_n = 0;
    logic [AW-1:0] tr_addr [4];
    logic          tr_we [4];
    int            checks = 0, fails = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dcas_unit #(.ADDR_W(AW), .REG_IDX_W(RW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .reg_sel(reg_sel),
        .addr_a(addr_a), .addr_b(addr_b), .op_wide(op_wide),
        .busy(busy), .done(done), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .mem_lock(mem_lock),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    assign mem_ack   = mem_req;
    assign mem_rdata = mem_arr[mem_addr];
    assign rf_rdata  = rf_arr[rf_raddr];

    always @(posedge clk) begin
        if (tr_clr) begin
            tr_n   <= 0;
            lock_n <= 0;
        end else begin
            if (mem_req && mem_ack) begin
                if (tr_n < 4) begin
                    tr_addr[tr_n] <= mem_addr;
                    tr_we[tr_n]   <= mem_we;
                end
                tr_n <= tr_n + 1;
            end
            if (mem_lock) lock_n <= lock_n + 1;
        end
        if (mem_req && mem_ack && mem_we)
            mem_arr[mem_addr] <= mem_wide ? mem_wdata
                                          : {mem_arr[mem_addr][31:16], mem_wdata[15:0]};
        if (rf_we) rf_arr[rf_waddr] <= rf_wdata;
        if (pl_en) begin
            if (pl_mem) mem_arr[pl_idx[AW-1:0]] <= pl_val;
            else        rf_arr[pl_idx[RW-1:0]]  <= pl_val;
        end
    end

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, act=%0d exp<%0d cycles", cyc, WATCHDOG);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    task automatic poke(input bit to_mem, input int idx, input logic [31:0] val);
        @(negedge clk);
        pl_en = 1'b1; pl_mem = to_mem; pl_idx = idx; pl_val = val;
        @(negedge clk);
        pl_en = 1'b0;
    endtask

    // expected {n,z,v,c} of m - c at width w
    function automatic logic [3:0] exp_flags(input logic [31:0] m, input logic [31:0] c, input bit w);
        longint wd, um, uc, diff, sm, sc, sd, half;
        logic n, z, v, b;
        wd   = w ? 32 : 16;
        half = longint'(1) << (wd - 1);
        um   = w ? longint'(m) : longint'(m[15:0]);
        uc   = w ? longint'(c) : longint'(c[15:0]);
        diff = (um - uc) & ((longint'(1) << wd) - 1);
        n = ((diff >> (wd - 1)) & 1) != 0;
        z = (diff == 0);
        b = (um < uc);
        sm = (um >= half) ? um - 2*half : um;
        sc = (uc >= half) ? uc - 2*half : uc;
        sd = sm - sc;
        v = (sd > half - 1) || (sd < -half);
        return {n, z, v, b};
    endfunction

    function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] nv, input bit w);
        return w ? nv : {o[31:16], nv[15:0]};
    endfunction

    task automatic run_op(input bit w, input int dc1, input int dc2, input int du1, input int du2,
                          input int a1, input int a2,
                          input logic [31:0] m1, input logic [31:0] m2,
                          input logic [31:0] vc1, input logic [31:0] vc2,
                          input logic [31:0] vu1, input logic [31:0] vu2,
                          input bit restart, input string ftag);
        logic [31:0] snap [8];
        logic [31:0] exp_rf [8];
        logic [31:0] c1, c2, u1, u2, em1, em2;
        logic [3:0]  ef;
        bit          eq1, eq2, wr, rf_ok;
        int          t, n_acc, saved_n;
        poke(0, du1, vu1); poke(0, du2, vu2);
        poke(0, dc1, vc1); poke(0, dc2, vc2);
        poke(1, a1, m1);   poke(1, a2, m2);
        for (int r = 0; r < 8; r++) snap[r] = rf_arr[r];
        c1 = snap[dc1]; c2 = snap[dc2]; u1 = snap[du1]; u2 = snap[du2];
        eq1 = w ? (m1 == c1) : (m1[15:0] == c1[15:0]);
        eq2 = w ? (m2 == c2) : (m2[15:0] == c2[15:0]);
        wr  = eq1 && eq2;
        ef  = eq1 ? exp_flags(m2, c2, w) : exp_flags(m1, c1, w);
        em1 = wr ? mrg(m1, u1, w) : m1;
        em2 = wr ? mrg(m2, u2, w) : m2;
        for (int r = 0; r < 8; r++) exp_rf[r] = snap[r];
        exp_rf[dc1] = mrg(c1, m1, w);
        exp_rf[dc2] = mrg(c2, m2, w);
        n_acc = wr ? 4 : 2;

        @(negedge clk); tr_clr = 1'b1;
        @(negedge clk); tr_clr = 1'b0;
        reg_sel = {dc1[RW-1:0], dc2[RW-1:0], du1[RW-1:0], du2[RW-1:0]};
        addr_a = a1[AW-1:0]; addr_b = a2[AW-1:0]; op_wide = w; start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (restart) begin
            @(negedge clk);
            reg_sel = ~reg_sel; addr_a = a2[AW-1:0]; addr_b = a1[AW-1:0]; start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        t = 0;
        while (!done && t < 100) begin @(negedge clk); t++; end
        chk(done, "R9 done pulse seen", 32'(done), 32'd1);
        chk({flag_n, flag_z, flag_v, flag_c} == ef, {ftag, " flags NZVC"},
            32'({flag_n, flag_z, flag_v, flag_c}), 32'(ef));
        chk(mem_arr[a1] == em1, "R3 R7 first location", mem_arr[a1], em1);
        chk(mem_arr[a2] == em2, "R3 R7 second location", mem_arr[a2], em2);
        chk(rf_arr[dc2] == exp_rf[dc2], "R6 second compare register", rf_arr[dc2], exp_rf[dc2]);
        chk(rf_arr[dc1] == exp_rf[dc1], "R6 first compare register", rf_arr[dc1], exp_rf[dc1]);
        rf_ok = 1'b1;
        for (int r = 0; r < 8; r++) if (rf_arr[r] !== exp_rf[r]) rf_ok = 1'b0;
        chk(rf_ok, "R1 register file contents", 32'(rf_ok), 32'd1);
        chk(tr_n == n_acc, "R3 access count", 32'(tr_n), 32'(n_acc));
        chk(tr_addr[0] == a1[AW-1:0] && !tr_we[0] && tr_addr[1] == a2[AW-1:0] && !tr_we[1],
            "R2 read order", {tr_addr[0], tr_addr[1]}, {a1[AW-1:0], a2[AW-1:0]});
        if (wr)
            chk(tr_addr[2] == a1[AW-1:0] && tr_we[2] && tr_addr[3] == a2[AW-1:0] && tr_we[3],
                "R3 write order", {tr_addr[2], tr_addr[3]}, {a1[AW-1:0], a2[AW-1:0]});
        chk(lock_n == n_acc, "R8 lock span", 32'(lock_n), 32'(n_acc));
        saved_n = tr_n;
        @(negedge clk);
        chk(!done && !busy, "R9 single-cycle done then idle", {30'd0, done, busy}, 32'd0);
        if (restart) begin
            repeat (4) @(negedge clk);
            chk(tr_n == saved_n && !busy, "R9 start while busy ignored", 32'(tr_n), 32'(saved_n));
        end
    endtask

    logic [31:0] vals [5];

    initial begin
        for (int k = 0; k < 16; k++) mem_arr[k] = 32'h0;
        for (int k = 0; k < 8; k++)  rf_arr[k]  = 32'h0;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !mem_req && !mem_lock && !rf_we, "R10 reset state",
            {27'd0, busy, done, mem_req, mem_lock, rf_we}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int wi = 0; wi < 2; wi++) begin
            bit w;
            w = (wi == 1);
            if (w) begin
                vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'h7FFFFFFF;
                vals[3] = 32'h80000000; vals[4] = 32'hFFFFFFFF;
            end else begin
                vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'h7FFF;
                vals[3] = 32'h8000; vals[4] = 32'hFFFF;
            end
            // first pair varies, second matches (R5, R7 upper halves differ in narrow mode)
            for (int i = 0; i < 5; i++) begin
                for (int j = 0; j < 5; j++) begin
                    int n;
                    n = i*5 + j;
                    run_op(w, n%8, (n+3)%8, (n+5)%8, (n+6)%8, n%16, (n+7)%16,
                           w ? vals[i] : (32'hA5A50000 | vals[i]), w ? 32'h3C3C3C3C : 32'h55553C3C,
                           w ? vals[j] : (32'h12340000 | vals[j]), w ? 32'h3C3C3C3C : 32'h77773C3C,
                           32'hCAFE0000 | 32'(n), 32'hBEEF0000 | 32'(n),
                           (n == 0), "R5 R7");
                end
            end
            // first matches, second varies: flags from the second pair
            for (int i = 0; i < 5; i++) begin
                for (int j = 0; j < 5; j++) begin
                    int n;
                    n = i*5 + j + 1;
                    run_op(w, (n+2)%8, (n+4)%8, (n+1)%8, n%8, (n+3)%16, (n+11)%16,
                           w ? 32'h01020304 : 32'hEEEE0304, w ? vals[i] : (32'h5A5A0000 | vals[i]),
                           w ? 32'h01020304 : 32'h11110304, w ? vals[j] : (32'h96960000 | vals[j]),
                           32'h600D0000 | 32'(n), 32'hF00D0000 | 32'(n),
                           1'b0, "R4 R5");
                end
            end
            // both pairs differ: first pair decides
            for (int i = 0; i < 5; i++) begin
                run_op(w, 1, 6, 3, 4, 2, 9,
                       vals[i], vals[(i+2)%5], vals[(i+1)%5], vals[(i+4)%5],
                       32'h0BAD0001, 32'h0BAD0002, 1'b0, "R4");
            end
            // same compare register twice: second pair lands last
            run_op(w, 5, 5, 0, 7, 4, 12, 32'h9999AAAA, 32'h4444BBBB,
                   32'h2222CCCC, 32'h2222CCCC, 32'h1, 32'h2, 1'b0, "R4 R6");
        end

        summary();
        $finish;
    end

endmodule